// File: doc/BRIEF.md
# Programmable Threshold Alarm Unit

The block watches a set of signed sensor data channels with two independent programmable alarms. Each alarm takes one channel chosen by a 4-bit source code, compares it with a 14-bit signed threshold at every sample strobe, and trips when the value is beyond the threshold. A polarity bit in the alarm's 16-bit magnitude word sets the direction of that comparison. The alarm state is held until the next strobe. It goes to a status register, and it can fire a one-cycle event-capture trigger.

Software programs the block through byte-wide writes. One control byte holds the per-alarm enables, the routing to a digital I/O line, the choice of line, the active level and the capture enables. A second control byte holds the two source codes. The pin driver owns the chosen line only while no higher-priority function claims it. Otherwise it releases the line.

Top module: `alarm_unit`

## Requirements
- R1: After reset all registers read as zero in effect, and `alarm_status_o`, `capture_trig_o`, `dio_oe_o` and `dio_o` are 0.
- R2: A write strobe stores `wr_data_i` at byte address 0x20 (alarm 1 magnitude, bits 7:0), 0x21 (alarm 1 magnitude, bits 15:8), 0x22 and 0x23 (alarm 2 magnitude, low and high), 0x28 (lower control byte) or 0x29 (upper control byte). The new value takes effect from the next clock. A write to any other address changes nothing.
- R3: With magnitude bit 15 = 1, an enabled alarm trips at a strobe when the selected value is strictly greater than the threshold. An equal value does not trip.
- R4: With magnitude bit 15 = 0, an enabled alarm trips when the selected value is strictly less than the threshold. Magnitude bits 13:0 are the threshold as a 14-bit two's-complement number, and channel data is signed.
- R5: Upper control byte bits 3:0 select the source channel of alarm 1 and bits 7:4 that of alarm 2, where code k selects channel k. A code of N_CH or more never trips.
- R6: Lower control byte bit 0 enables alarm 1 and bit 1 enables alarm 2. A disabled alarm is inactive after the next strobe.
- R7: Alarm state changes only on a clock edge where `sample_i` is 1 and shows in the next cycle on `alarm_status_o` (bit 0 = alarm 1, bit 1 = alarm 2). Between strobes it holds even if channel data changes. A comparison uses the configuration held before a write in the same cycle.
- R8: Lower control byte bits 6 and 7 enable capture for alarms 1 and 2. `capture_trig_o` pulses for one cycle, together with the status change, when a capture-enabled alarm goes from inactive to active.
- R9: Lower control byte bits 2 and 3 route alarms 1 and 2 to the pin, bit 4 selects line 0 or 1, and bit 5 = 1 means active high. When any route bit is set, the selected line has `dio_oe_o` = 1. It drives the active level while any routed alarm is active and the inactive level otherwise. Any other line has enable 0 and value 0.
- R10: When `line_busy_i` is 1 for the selected line, the line is released (`dio_oe_o` and `dio_o` 0 for it).
- R11: Magnitude words 0x81B0 (432) and 0x8370 (880) give greater-than trip points at 432 and 880 codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 8 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| sample_i | input | 1 | Sample strobe, comparisons run on it |
| ch_data_i | input | N_CH*DATA_W | Signed channel data, channel k at bits k*DATA_W upward |
| line_busy_i | input | 2 | Higher-priority function holds I/O line |
| alarm_status_o | output | 2 | Alarm active flags |
| capture_trig_o | output | 1 | Event-capture trigger pulse |
| dio_oe_o | output | 2 | Alarm driver owns the line |
| dio_o | output | 2 | Alarm driver line level |

## Verification
The bench builds the block with the default N_CH = 4 and DATA_W = 14. With four channels, source codes 4 to 15 are the out-of-range cases that must never trip. With a data width equal to the threshold width, the comparisons at equality and across the sign boundary can be hit exactly, including negative thresholds with less-than polarity. Both I/O lines, both active levels and writes that land in the same cycle as a strobe are driven.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int N_ALM   = 2;
  localparam int N_LINES = 2;
  localparam int THR_W   = 14;
  localparam int SRC_W   = 4;

  localparam logic [7:0] ADDR_MAG0_LO = 8'h20;
  localparam logic [7:0] ADDR_MAG0_HI = 8'h21;
  localparam logic [7:0] ADDR_MAG1_LO = 8'h22;
  localparam logic [7:0] ADDR_MAG1_HI = 8'h23;
  localparam logic [7:0] ADDR_CTL_LO  = 8'h28;
  localparam logic [7:0] ADDR_CTL_HI  = 8'h29;

  typedef struct packed {
    logic             en;
    logic             route;
    logic             cap;
    logic             gt;
    logic [THR_W-1:0] thr;
    logic [SRC_W-1:0] src;
  } alm_cfg_t;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [7:0]             wr_addr_i,
  input  logic [7:0]             wr_data_i,
  output alm_cfg_t [N_ALM-1:0]   cfg_o,
  output logic                   line_sel_o,
  output logic                   act_high_o
);
  logic [15:0] mag_q [N_ALM];
  logic [7:0]  ctl_lo_q, ctl_hi_q;
  logic        hit;

  always_comb begin
    hit = wr_addr_i inside {ADDR_MAG0_LO, ADDR_MAG0_HI, ADDR_MAG1_LO,
                            ADDR_MAG1_HI, ADDR_CTL_LO, ADDR_CTL_HI};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q[0] <= '0;
      mag_q[1] <= '0;
      ctl_lo_q <= '0;
      ctl_hi_q <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_MAG0_LO: mag_q[0][7:0]  <= wr_data_i;
        ADDR_MAG0_HI: mag_q[0][15:8] <= wr_data_i;
        ADDR_MAG1_LO: mag_q[1][7:0]  <= wr_data_i;
        ADDR_MAG1_HI: mag_q[1][15:8] <= wr_data_i;
        ADDR_CTL_LO:  ctl_lo_q       <= wr_data_i;
        ADDR_CTL_HI:  ctl_hi_q       <= wr_data_i;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < N_ALM; k++) begin : g_cfg
    assign cfg_o[k].en    = ctl_lo_q[k];
    assign cfg_o[k].route = ctl_lo_q[2+k];
    assign cfg_o[k].cap   = ctl_lo_q[6+k];
    assign cfg_o[k].gt    = mag_q[k][15];
    assign cfg_o[k].thr   = mag_q[k][THR_W-1:0];
    assign cfg_o[k].src   = ctl_hi_q[k*SRC_W +: SRC_W];
  end

  assign line_sel_o = ctl_lo_q[4];
  assign act_high_o = ctl_lo_q[5];

  AST_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> ($stable(ctl_lo_q) && $stable(ctl_hi_q)
                           && $stable(mag_q[0]) && $stable(mag_q[1]))); // R2
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic [N_CH*DATA_W-1:0]   ch_data_i,
  input  alm_cfg_t                 cfg_i,
  output logic                     active_o,
  output logic                     rise_o
);
  localparam int SEL_W = $clog2(N_CH);

  logic signed [DATA_W-1:0] vals [N_CH];
  logic signed [DATA_W-1:0] val, thr_ext;
  logic                     src_ok, trip;
  logic                     active_q, rise_q;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign vals[i] = ch_data_i[i*DATA_W +: DATA_W];
  end

  always_comb begin
    src_ok  = 32'(cfg_i.src) < N_CH;
    val     = src_ok ? vals[cfg_i.src[SEL_W-1:0]] : '0;
    thr_ext = DATA_W'($signed(cfg_i.thr));
    trip    = cfg_i.en && src_ok && (cfg_i.gt ? (val > thr_ext) : (val < thr_ext));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rise_q   <= 1'b0;
    end else begin
      rise_q <= sample_i && trip && !active_q && cfg_i.cap;
      if (sample_i) active_q <= trip;
    end
  end

  assign active_o = active_q;
  assign rise_o   = rise_q;

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !cfg_i.en) |=> !active_q); // R6
  AST_BAD_SRC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !src_ok) |=> !active_q); // R5
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(active_q)); // R7
  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |=> !rise_q); // R8
  AST_RISE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> (active_q && !$past(active_q))); // R8
endmodule

// File: rtl/alarm_pin.sv
module alarm_pin
  import alarm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_ALM-1:0]   active_i,
  input  logic [N_ALM-1:0]   route_i,
  input  logic               line_sel_i,
  input  logic               act_high_i,
  input  logic [N_LINES-1:0] busy_i,
  output logic [N_LINES-1:0] oe_o,
  output logic [N_LINES-1:0] dio_o
);
  logic any_on, used;

  assign any_on = |(active_i & route_i);
  assign used   = |route_i;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    assign oe_o[l]  = used && (32'(line_sel_i) == l) && !busy_i[l];
    assign dio_o[l] = oe_o[l] && (act_high_i ? any_on : !any_on);

    AST_YIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i[l] |-> (!oe_o[l] && !dio_o[l])); // R10
  end

  AST_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(oe_o)); // R9
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [7:0]             wr_addr_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   sample_i,
  input  logic [N_CH*DATA_W-1:0] ch_data_i,
  input  logic [1:0]             line_busy_i,
  output logic [1:0]             alarm_status_o,
  output logic                   capture_trig_o,
  output logic [1:0]             dio_oe_o,
  output logic [1:0]             dio_o
);
  alm_cfg_t [N_ALM-1:0] cfg;
  logic                 line_sel, act_high;
  logic [N_ALM-1:0]     active, rise, route;

  alarm_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cfg_o(cfg), .line_sel_o(line_sel), .act_high_o(act_high)
  );

  for (genvar k = 0; k < N_ALM; k++) begin : g_alm
    alarm_cmp #(.N_CH(N_CH), .DATA_W(DATA_W)) u_cmp (
      .clk_i, .rst_ni, .sample_i, .ch_data_i,
      .cfg_i(cfg[k]), .active_o(active[k]), .rise_o(rise[k])
    );
    assign route[k] = cfg[k].route;
  end

  alarm_pin u_pin (
    .clk_i, .rst_ni, .active_i(active), .route_i(route),
    .line_sel_i(line_sel), .act_high_i(act_high), .busy_i(line_busy_i),
    .oe_o(dio_oe_o), .dio_o(dio_o)
  );

  assign alarm_status_o = active;
  assign capture_trig_o = |rise;

  AST_TRIG_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_trig_o |-> $past(sample_i)); // R8
  AST_STATUS_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(alarm_status_o) |-> $past(sample_i)); // R7
endmodule

// File: tb/alarm_unit_tb.sv
module alarm_unit_tb;
  localparam int PERIOD = 10;
  localparam int N_CH   = 4;
  localparam int DW     = 14;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, smp = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [N_CH*DW-1:0] ch_data = '0;
  logic [1:0] busy = 0;
  logic [1:0] st, oe, dv;
  logic trig;

  always #(PERIOD/2) clk = ~clk;

  alarm_unit #(.N_CH(N_CH), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sample_i(smp), .ch_data_i(ch_data),
    .line_busy_i(busy), .alarm_status_o(st), .capture_trig_o(trig),
    .dio_oe_o(oe), .dio_o(dv)
  );

  typedef struct {
    logic [1:0] st;
    logic       trig;
    logic [1:0] oe;
    logic [1:0] dv;
    string      tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, bad = 0;
  bit done = 0;

  // reference model of the programmed state
  logic [15:0] m_mag [2];
  logic [7:0]  m_lo = 0, m_hi = 0;
  logic [1:0]  m_act = 0;
  logic signed [DW-1:0] ch [N_CH];

  function automatic logic trip(int k);
    logic [3:0] s;
    logic signed [DW-1:0] th;
    s  = (k == 1) ? m_hi[7:4] : m_hi[3:0];
    th = m_mag[k][13:0];
    if (!m_lo[k] || s >= 4'(N_CH)) return 1'b0;
    return m_mag[k][15] ? (ch[s] > th) : (ch[s] < th);
  endfunction

  task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                      input logic s, input logic [1:0] b, input string tag);
    exp_t e;
    logic [1:0] nact;
    logic any_on;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; smp = s; busy = b;
    for (int i = 0; i < N_CH; i++) ch_data[i*DW +: DW] = ch[i];
    nact = m_act;
    e.trig = 1'b0;
    if (s) begin
      for (int k = 0; k < 2; k++) begin
        nact[k] = trip(k);
        if (nact[k] && !m_act[k] && m_lo[6+k]) e.trig = 1'b1;
      end
    end
    m_act = nact;
    if (w) begin
      case (a)
        8'h20: m_mag[0][7:0]  = d;
        8'h21: m_mag[0][15:8] = d;
        8'h22: m_mag[1][7:0]  = d;
        8'h23: m_mag[1][15:8] = d;
        8'h28: m_lo = d;
        8'h29: m_hi = d;
        default: ;
      endcase
    end
    any_on = |(m_act & m_lo[3:2]);
    for (int l = 0; l < 2; l++) begin
      e.oe[l] = (|m_lo[3:2]) && (m_lo[4] == l[0]) && !b[l];
      e.dv[l] = e.oe[l] && (m_lo[5] ? any_on : !any_on);
    end
    e.st  = m_act;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 8'h00, 1'b0, busy, tag);
  endtask

  // monitor: compares each expected item one edge after it was driven
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (st !== e.st || trig !== e.trig || oe !== e.oe || dv !== e.dv) begin
          bad++;
          $display("FAIL %s: st=%b trig=%b oe=%b dio=%b expected st=%b trig=%b oe=%b dio=%b",
                   e.tag, st, trig, oe, dv, e.st, e.trig, e.oe, e.dv);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    m_mag[0] = 0; m_mag[1] = 0;
    for (int i = 0; i < N_CH; i++) ch[i] = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (st !== 2'b00 || trig !== 1'b0 || oe !== 2'b00 || dv !== 2'b00) begin
      bad++;
      $display("FAIL R1 reset: st=%b trig=%b oe=%b dio=%b expected all 0", st, trig, oe, dv);
    end
    rst_n = 1;

    // R11 example trip points, alarm 1 on ch1, alarm 2 on ch0
    step(1, 8'h20, 8'hB0, 0, 2'b00, "R2 mag1 low");
    step(1, 8'h21, 8'h81, 0, 2'b00, "R2 mag1 high");
    step(1, 8'h22, 8'h70, 0, 2'b00, "R2 mag2 low");
    step(1, 8'h23, 8'h83, 0, 2'b00, "R2 mag2 high");
    step(1, 8'h29, 8'h01, 0, 2'b00, "R5 sources");
    step(1, 8'h28, 8'h7F, 0, 2'b00, "R9 route line1 active high");
    ch[0] = 880; ch[1] = 432;
    step(0, 0, 0, 1, 2'b00, "R11 R3 equal values do not trip");
    ch[0] = 881;
    step(0, 0, 0, 1, 2'b00, "R11 R3 alarm2 above 880");
    ch[0] = 0; ch[1] = 1000;
    idle("R7 hold without strobe");
    ch[0] = 881;
    step(0, 0, 0, 1, 2'b00, "R8 R11 alarm1 above 432 fires capture");
    step(0, 0, 0, 1, 2'b00, "R8 no repeat while active");
    step(0, 0, 0, 0, 2'b10, "R10 busy line released");
    step(0, 0, 0, 0, 2'b01, "R10 busy on other line no effect");
    step(1, 8'h28, 8'h5F, 0, 2'b00, "R9 active low while alarms on");
    // stray addresses
    step(1, 8'h24, 8'hFF, 0, 2'b00, "R2 stray 0x24");
    step(1, 8'h27, 8'h00, 0, 2'b00, "R2 stray 0x27");
    step(1, 8'h2A, 8'h00, 0, 2'b00, "R2 stray 0x2A");
    step(1, 8'h1F, 8'h00, 0, 2'b00, "R2 stray 0x1F");
    step(0, 0, 0, 1, 2'b00, "R2 config intact after stray writes");
    // R4 less-than with negative threshold on alarm 2 (-1)
    step(1, 8'h22, 8'hFF, 0, 2'b00, "R2 mag2 low -1");
    step(1, 8'h23, 8'h3F, 0, 2'b00, "R4 mag2 high less-than");
    ch[0] = -1;
    step(0, 0, 0, 1, 2'b00, "R4 equal negative does not trip");
    ch[0] = -2;
    step(0, 0, 0, 1, 2'b00, "R4 below negative threshold trips");
    step(1, 8'h21, 8'h01, 0, 2'b00, "R4 mag1 less-than 432");
    ch[1] = -5;
    step(0, 0, 0, 1, 2'b00, "R4 negative value below positive threshold");
    // write in strobe cycle uses old config
    ch[2] = 8000; ch[3] = -8000;
    step(1, 8'h29, 8'h23, 1, 2'b00, "R7 write with strobe uses old sources");
    step(0, 0, 0, 1, 2'b00, "R5 new sources ch3 and ch2");
    step(1, 8'h29, 8'hF4, 0, 2'b00, "R5 out of range codes");
    step(0, 0, 0, 1, 2'b00, "R5 codes 4 and 15 never trip");
    step(1, 8'h29, 8'h01, 0, 2'b00, "R5 restore sources");
    ch[0] = -100; ch[1] = -100;
    step(0, 0, 0, 1, 2'b00, "R8 both rise with capture");
    step(1, 8'h28, 8'h7C, 0, 2'b00, "R6 disable both");
    step(0, 0, 0, 1, 2'b00, "R6 disabled alarms go inactive");
    step(1, 8'h28, 8'h26, 0, 2'b00, "R9 line0 active high alarm2 only");
    step(0, 0, 0, 1, 2'b00, "R6 alarm2 enabled, no capture");
    step(1, 8'h28, 8'h22, 0, 2'b00, "R9 no route leaves lines free");
    idle("R7 idle");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule